// File: doc/BRIEF.md
# I2C Slave Address and General-Call Recognizer

This block sits behind an I2C bit-level shifter that delivers whole received bytes, plus one-cycle start and stop strobes. The first byte after any start or stop is treated as an address byte. Its upper seven bits are compared with four programmable slave address fields. If the general-call response is enabled, the byte is also compared with the all-zero general-call address with write direction. The block returns an acknowledge decision for every byte. It reports which address field matched and the direction bit. While the block is addressed, it acknowledges the data bytes that follow.

The byte that follows an accepted general call is read as a command. Value 0x06 asks for a reset of the slave interface and reloads the pin-strapped low address bits of field 0. Value 0x04 only reloads those bits. When the hardware general-call option is enabled, the byte is first compared with an alternate 8-bit ID. A match raises its own sticky flag and runs no command. The general-call status flag and the hardware general-call flag are sticky until a clear pulse. An interrupt output is their OR.

Top module: `i2c_addr_recog`

## Requirements
- R1: In the address phase, with the slave enabled, bits 7:1 of an address byte are compared with every stored 7-bit address field. A field value of zero never matches. On a match the byte is acknowledged and `match_idx` takes the lowest matching index. `addressed` stays high and every later data byte is acknowledged, until the next start or stop.
- R2: While `cfg_slave_en` is low, no address byte is acknowledged. This includes 0x00. No flag or pulse is raised.
- R3: The byte 0x00 is acknowledged as a general call only while `cfg_gc_en` is high. While it is low, 0x00 is not acknowledged, even when an address field holds zero. The byte 0x01 is never a general call.
- R4: A general-call data byte of 0x06 gives a one-cycle `soft_rst_req` and a one-cycle `addr_load` in the same cycle.
- R5: `gc_status` is set by every accepted general-call address. It stays set until `flag_clr` is high for a cycle. A set in the same cycle as a clear wins.
- R6: A general-call data byte of 0x04 gives an `addr_load` pulse and no `soft_rst_req`. On every `addr_load`, address bits 3:1 of field 0 take the value of `hw_addr`, and its other bits are kept. A software write to field 0 in the same cycle takes precedence.
- R7: With `cfg_gc_en` and `cfg_hwgc_en` both high, a general-call data byte equal to all 8 bits of the alternate ID sets the sticky `hwgc_flag` and runs no command. A byte that does not match is decoded as in R4 and R6.
- R8: The general-call data byte itself is acknowledged. Bytes after it are not acknowledged until a start or stop. The same holds for bytes after an unmatched address byte.
- R9: On an address match, `rw_dir` takes bit 0 of the address byte (1 = read).
- R10: A start or stop strobe returns the block to the address phase. A byte strobed in the same cycle is dropped, and `ack_valid` stays low.
- R11: `irq` is high exactly while `gc_status` or `hwgc_flag` is high.
- R12: After reset, all address fields and the alternate ID are zero, flags and pulses are low, and the block is in the address phase. `id_wr_sel` values 0..3 write address fields from `id_wr_data[7:1]`. Value 4 writes the alternate ID from all 8 bits.
- R13: Every byte that is not dropped gives `ack_valid` for exactly one cycle, one clock after `byte_vld`, with `ack` holding the decision. `ack` is never high without `ack_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slave_en | input | 1 | Slave response enable |
| cfg_gc_en | input | 1 | General-call response enable |
| cfg_hwgc_en | input | 1 | Hardware general-call compare enable |
| id_wr_en | input | 1 | Write strobe for address fields / alternate ID |
| id_wr_sel | input | 3 | Write target: 0..3 field, 4 alternate ID |
| id_wr_data | input | 8 | Write data |
| hw_addr | input | 3 | Pin-strapped low address bits |
| start_det | input | 1 | Start or repeated-start strobe |
| stop_det | input | 1 | Stop strobe |
| byte_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| flag_clr | input | 1 | Clears sticky flags |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack | output | 1 | Acknowledge decision |
| addressed | output | 1 | Addressed by a matching field |
| match_idx | output | 2 | Index of matched field |
| rw_dir | output | 1 | Direction bit of matched address |
| gc_status | output | 1 | Sticky general-call status |
| hwgc_flag | output | 1 | Sticky hardware general-call flag |
| irq | output | 1 | Interrupt, OR of sticky flags |
| soft_rst_req | output | 1 | Slave interface reset request pulse |
| addr_load | output | 1 | Address reprogram strobe |

## Verification
Every result is registered once. A byte, start, stop or clear presented before a rising edge therefore shows up at the outputs right after that edge. This includes the acknowledge decision, match index, direction, flags, command pulses and the updated field 0. The bench drives inputs on falling edges. A behavioural model advances on each rising edge, and all outputs are compared with it on the next falling edge. Directed checks follow the same one-edge rule and sample immediately after the edge that consumed the byte.

// File: rtl/i2c_recog_pkg.sv
package i2c_recog_pkg;

    typedef enum logic [1:0] {
        PH_ADDR   = 2'd0,
        PH_GCDATA = 2'd1,
        PH_SLAVE  = 2'd2,
        PH_SKIP   = 2'd3
    } phase_e;

    localparam logic [7:0] GC_ADDR_BYTE = 8'h00;

endpackage

// File: rtl/i2c_id_bank.sv
module i2c_id_bank #(
    parameter int N_ID  = 4,
    parameter int HW_W  = 3,
    parameter int SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [7:0]            wr_data,
    input  logic                  load,
    input  logic [HW_W-1:0]       hw_addr,
    output logic [N_ID-1:0][6:0]  fields,
    output logic [7:0]            alt_id
);

    logic [N_ID-1:0][6:0] fld_d, fld_q;
    logic [7:0]           alt_d, alt_q;

    always_comb begin
        fld_d = fld_q;
        alt_d = alt_q;
        if (load) begin
            fld_d[0][HW_W-1:0] = hw_addr;
        end
        for (int k = 0; k < N_ID; k++) begin
            if (wr_en && (wr_sel == SEL_W'(k))) begin
                fld_d[k] = wr_data[7:1];
            end
        end
        if (wr_en && (wr_sel == SEL_W'(N_ID))) begin
            alt_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
            alt_q <= '0;
        end else begin
            fld_q <= fld_d;
            alt_q <= alt_d;
        end
    end

    assign fields = fld_q;
    assign alt_id = alt_q;

    AST_HW_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !(wr_en && wr_sel == '0)) |=> (fld_q[0][HW_W-1:0] == $past(hw_addr))) // R6
        else $error("hw address bits not loaded");

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !load) |=> $stable(fld_q) && $stable(alt_q)) // R12
        else $error("address storage changed without cause");

endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
    parameter int N_ID  = 4,
    parameter int IDX_W = 2
) (
    input  logic [6:0]            addr_f,
    input  logic [N_ID-1:0][6:0]  fields,
    output logic                  hit,
    output logic [IDX_W-1:0]      idx
);

    logic [N_ID-1:0] eq;

    generate
        for (genvar g = 0; g < N_ID; g++) begin : g_cmp
            assign eq[g] = (addr_f == fields[g]) && (addr_f != 7'd0);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = N_ID - 1; k >= 0; k--) begin
            if (eq[k]) begin
                hit = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

    always_comb begin
        assert (!hit || eq[idx]) else $error("priority pick not a hit"); // R1
    end

endmodule

// File: rtl/i2c_gc_cmd.sv
module i2c_gc_cmd #(
    parameter logic [7:0] RESET_CMD = 8'h06,
    parameter logic [7:0] LOAD_CMD  = 8'h04
) (
    input  logic [7:0] data,
    input  logic [7:0] alt_id,
    input  logic       alt_en,
    output logic       is_alt,
    output logic       do_reset,
    output logic       do_load
);

    always_comb begin
        is_alt   = alt_en && (data == alt_id);
        do_reset = !is_alt && (data == RESET_CMD);
        do_load  = !is_alt && ((data == RESET_CMD) || (data == LOAD_CMD));
    end

    always_comb begin
        assert (!(is_alt && do_load)) else $error("alt match ran a command"); // R7
    end

endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
    import i2c_recog_pkg::*;
#(
    parameter int N_ID  = 4,
    parameter int HW_W  = 3,
    parameter int SEL_W = $clog2(N_ID + 1),
    parameter int IDX_W = (N_ID > 1) ? $clog2(N_ID) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_slave_en,
    input  logic             cfg_gc_en,
    input  logic             cfg_hwgc_en,
    input  logic             id_wr_en,
    input  logic [SEL_W-1:0] id_wr_sel,
    input  logic [7:0]       id_wr_data,
    input  logic [HW_W-1:0]  hw_addr,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             byte_vld,
    input  logic [7:0]       rx_byte,
    input  logic             flag_clr,
    output logic             ack_valid,
    output logic             ack,
    output logic             addressed,
    output logic [IDX_W-1:0] match_idx,
    output logic             rw_dir,
    output logic             gc_status,
    output logic             hwgc_flag,
    output logic             irq,
    output logic             soft_rst_req,
    output logic             addr_load
);

    typedef struct packed {
        phase_e           phase;
        logic             ack_vld;
        logic             ack;
        logic [IDX_W-1:0] idx;
        logic             rw;
        logic             gc_st;
        logic             hwgc;
        logic             srst;
        logic             load;
    } st_t;

    st_t r_d, r_q;

    logic [N_ID-1:0][6:0] fields;
    logic [7:0]           alt_id;
    logic                 hit;
    logic [IDX_W-1:0]     hit_idx;
    logic                 is_alt, do_reset, do_load;
    logic                 frame_evt, take_byte, is_gc_addr;

    i2c_id_bank #(.N_ID(N_ID), .HW_W(HW_W), .SEL_W(SEL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (id_wr_en),
        .wr_sel  (id_wr_sel),
        .wr_data (id_wr_data),
        .load    (r_d.load),
        .hw_addr (hw_addr),
        .fields  (fields),
        .alt_id  (alt_id)
    );

    i2c_addr_cmp #(.N_ID(N_ID), .IDX_W(IDX_W)) u_cmp (
        .addr_f (rx_byte[7:1]),
        .fields (fields),
        .hit    (hit),
        .idx    (hit_idx)
    );

    i2c_gc_cmd u_cmd (
        .data     (rx_byte),
        .alt_id   (alt_id),
        .alt_en   (cfg_hwgc_en && cfg_gc_en),
        .is_alt   (is_alt),
        .do_reset (do_reset),
        .do_load  (do_load)
    );

    assign frame_evt  = start_det || stop_det;
    assign take_byte  = byte_vld && !frame_evt;
    assign is_gc_addr = (rx_byte == GC_ADDR_BYTE);

    always_comb begin
        r_d         = r_q;
        r_d.ack_vld = 1'b0;
        r_d.ack     = 1'b0;
        r_d.srst    = 1'b0;
        r_d.load    = 1'b0;
        if (flag_clr) begin
            r_d.gc_st = 1'b0;
            r_d.hwgc  = 1'b0;
        end
        if (frame_evt) begin
            r_d.phase = PH_ADDR;
        end else if (take_byte) begin
            r_d.ack_vld = 1'b1;
            unique case (r_q.phase)
                PH_ADDR: begin
                    if (!cfg_slave_en) begin
                        r_d.phase = PH_SKIP;
                    end else if (is_gc_addr && cfg_gc_en) begin
                        r_d.ack   = 1'b1;
                        r_d.gc_st = 1'b1;
                        r_d.phase = PH_GCDATA;
                    end else if (hit) begin
                        r_d.ack   = 1'b1;
                        r_d.idx   = hit_idx;
                        r_d.rw    = rx_byte[0];
                        r_d.phase = PH_SLAVE;
                    end else begin
                        r_d.phase = PH_SKIP;
                    end
                end
                PH_GCDATA: begin
                    r_d.ack   = 1'b1;
                    r_d.phase = PH_SKIP;
                    if (is_alt) begin
                        r_d.hwgc = 1'b1;
                    end
                    r_d.srst = do_reset;
                    r_d.load = do_load;
                end
                PH_SLAVE: begin
                    r_d.ack = cfg_slave_en;
                end
                default: begin
                    r_d.ack = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_valid    = r_q.ack_vld;
    assign ack          = r_q.ack;
    assign addressed    = (r_q.phase == PH_SLAVE);
    assign match_idx    = r_q.idx;
    assign rw_dir       = r_q.rw;
    assign gc_status    = r_q.gc_st;
    assign hwgc_flag    = r_q.hwgc;
    assign irq          = r_q.gc_st || r_q.hwgc;
    assign soft_rst_req = r_q.srst;
    assign addr_load    = r_q.load;

    AST_DISABLED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && r_q.phase == PH_ADDR && !cfg_slave_en) |=> (ack_valid && !ack)) // R2
        else $error("acknowledged while slave disabled");

    AST_GC_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && r_q.phase == PH_ADDR && cfg_slave_en && cfg_gc_en && is_gc_addr)
        |=> (gc_status && ack)) // R5
        else $error("general call not flagged");

    AST_RESET_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> addr_load) // R4
        else $error("reset request without address load");

    AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ack_valid) // R13
        else $error("ack without valid");

    AST_FRAME_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> (!ack_valid && r_q.phase == PH_ADDR)) // R10
        else $error("frame strobe did not restart address phase");

    AST_HWGC_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hwgc_flag) |-> !addr_load) // R7
        else $error("alternate match also ran a command");

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (gc_status || hwgc_flag)) // R11
        else $error("irq mismatch");

endmodule

// File: tb/i2c_addr_recog_tb.sv
module i2c_addr_recog_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_slave_en = 1'b0, cfg_gc_en = 1'b0, cfg_hwgc_en = 1'b0;
    logic       id_wr_en = 1'b0;
    logic [2:0] id_wr_sel = '0;
    logic [7:0] id_wr_data = '0;
    logic [2:0] hw_addr = '0;
    logic       start_det = 1'b0, stop_det = 1'b0, byte_vld = 1'b0, flag_clr = 1'b0;
    logic [7:0] rx_byte = '0;

    logic       ack_valid, ack, addressed, rw_dir, gc_status, hwgc_flag, irq;
    logic       soft_rst_req, addr_load;
    logic [1:0] match_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 0;

    always #5 clk = ~clk;

    i2c_addr_recog u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_slave_en(cfg_slave_en), .cfg_gc_en(cfg_gc_en), .cfg_hwgc_en(cfg_hwgc_en),
        .id_wr_en(id_wr_en), .id_wr_sel(id_wr_sel), .id_wr_data(id_wr_data),
        .hw_addr(hw_addr), .start_det(start_det), .stop_det(stop_det),
        .byte_vld(byte_vld), .rx_byte(rx_byte), .flag_clr(flag_clr),
        .ack_valid(ack_valid), .ack(ack), .addressed(addressed), .match_idx(match_idx),
        .rw_dir(rw_dir), .gc_status(gc_status), .hwgc_flag(hwgc_flag), .irq(irq),
        .soft_rst_req(soft_rst_req), .addr_load(addr_load)
    );

    // behavioural reference: 0 address, 1 gc data, 2 addressed, 3 ignore
    int       m_ph = 0;
    bit [7:0] m_id [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
    bit [7:0] m_alt = 8'h00;
    bit       m_ackv = 0, m_ack = 0, m_rw = 0, m_gc = 0, m_hw = 0, m_srst = 0, m_load = 0;
    int       m_idx = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_alt = 0; m_ackv = 0; m_ack = 0; m_rw = 0;
            m_gc = 0; m_hw = 0; m_srst = 0; m_load = 0; m_idx = 0;
            foreach (m_id[i]) m_id[i] = 0;
        end else begin
            int found;
            bit [7:0] alt_now;
            alt_now = m_alt;
            m_ackv = 0; m_ack = 0; m_srst = 0; m_load = 0;
            if (flag_clr) begin m_gc = 0; m_hw = 0; end
            if (start_det || stop_det) begin
                m_ph = 0;
            end else if (byte_vld) begin
                m_ackv = 1;
                if (m_ph == 0) begin
                    found = -1;
                    for (int k = 3; k >= 0; k--)
                        if (rx_byte[7:1] != 0 && rx_byte[7:1] == m_id[k][7:1]) found = k;
                    if (!cfg_slave_en) m_ph = 3;
                    else if (rx_byte == 8'h00 && cfg_gc_en) begin m_ack = 1; m_gc = 1; m_ph = 1; end
                    else if (found >= 0) begin m_ack = 1; m_idx = found; m_rw = rx_byte[0]; m_ph = 2; end
                    else m_ph = 3;
                end else if (m_ph == 1) begin
                    m_ack = 1; m_ph = 3;
                    if (cfg_gc_en && cfg_hwgc_en && rx_byte == alt_now) m_hw = 1;
                    else if (rx_byte == 8'h06) begin m_srst = 1; m_load = 1; end
                    else if (rx_byte == 8'h04) m_load = 1;
                end else if (m_ph == 2) begin
                    m_ack = cfg_slave_en;
                end
            end
            if (m_load) m_id[0][3:1] = hw_addr;
            if (id_wr_en) begin
                if (id_wr_sel < 4) m_id[id_wr_sel] = {id_wr_data[7:1], 1'b0};
                else if (id_wr_sel == 4) m_alt = id_wr_data;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R13 ack_valid model", ack_valid, m_ackv);
            chk("R1 ack model", ack, m_ack);
            chk("R1 addressed model", addressed, m_ph == 2);
            chk("R1 match_idx model", match_idx, m_idx);
            chk("R9 rw_dir model", rw_dir, m_rw);
            chk("R5 gc_status model", gc_status, m_gc);
            chk("R7 hwgc_flag model", hwgc_flag, m_hw);
            chk("R11 irq model", irq, m_gc | m_hw);
            chk("R4 soft_rst_req model", soft_rst_req, m_srst);
            chk("R6 addr_load model", addr_load, m_load);
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    task automatic send(input logic [7:0] b);
        byte_vld = 1; rx_byte = b;
        @(negedge clk);
        byte_vld = 0;
    endtask

    task automatic frame_start();
        start_det = 1; @(negedge clk); start_det = 0;
    endtask

    task automatic frame_stop();
        stop_det = 1; @(negedge clk); stop_det = 0;
    endtask

    task automatic wr_id(input logic [2:0] sel, input logic [7:0] val);
        id_wr_en = 1; id_wr_sel = sel; id_wr_data = val;
        @(negedge clk);
        id_wr_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset ack_valid", ack_valid, 0);
        chk("R12 reset gc_status", gc_status, 0);
        chk("R12 reset addressed", addressed, 0);

        // R3: zero address with general call disabled, fields all zero
        cfg_slave_en = 1;
        frame_start();
        send(8'h00);
        chk("R3 gc disabled no ack", ack, 0);
        send(8'h55);
        chk("R8 byte after miss not acked", ack, 0);
        frame_stop();

        wr_id(3'd0, 8'h20); wr_id(3'd1, 8'h42); wr_id(3'd2, 8'h84); wr_id(3'd3, 8'hA7);
        wr_id(3'd4, 8'h35);

        // R1 / R9 each field
        for (int k = 0; k < 4; k++) begin
            logic [7:0] a;
            a = (k == 0) ? 8'h20 : (k == 1) ? 8'h43 : (k == 2) ? 8'h84 : 8'hA6;
            frame_start();
            send(a);
            chk("R1 field ack", ack, 1);
            chk("R1 field index", match_idx, k);
            chk("R9 direction", rw_dir, a[0]);
            send(8'h99);
            chk("R1 data acked while addressed", ack, 1);
            frame_stop();
            chk("R10 stop leaves addressed", addressed, 0);
        end

        // R8 unmatched address
        frame_start();
        send(8'h7E);
        chk("R8 unmatched no ack", ack, 0);
        chk("R13 valid on miss", ack_valid, 1);

        // R10 repeated start collides with a byte
        start_det = 1; byte_vld = 1; rx_byte = 8'h42;
        @(negedge clk);
        start_det = 0; byte_vld = 0;
        chk("R10 dropped byte", ack_valid, 0);
        send(8'h42);
        chk("R10 address phase after start", ack, 1);
        frame_stop();

        // R3 0x01 not a general call
        cfg_gc_en = 1;
        frame_start();
        send(8'h01);
        chk("R3 0x01 not gc", ack, 0);

        // R4 reset command, R5 status, R6 load
        hw_addr = 3'b101;
        frame_start();
        send(8'h00);
        chk("R3 gc ack", ack, 1);
        chk("R5 gc status set", gc_status, 1);
        send(8'h06);
        chk("R4 soft reset pulse", soft_rst_req, 1);
        chk("R4 load pulse", addr_load, 1);
        chk("R8 gc data acked", ack, 1);
        send(8'h06);
        chk("R8 after gc data no ack", ack, 0);
        chk("R4 pulse one cycle", soft_rst_req, 0);
        frame_start();
        send(8'h2A);
        chk("R6 reloaded field 0 matches", ack, 1);
        chk("R6 reloaded index", match_idx, 0);
        frame_start();
        send(8'h20);
        chk("R6 old field 0 gone", ack, 0);
        frame_stop();

        // R5 clear, R11 irq
        chk("R11 irq with status", irq, 1);
        flag_clr = 1; @(negedge clk); flag_clr = 0;
        chk("R5 cleared", gc_status, 0);
        chk("R11 irq cleared", irq, 0);

        // R6 load-only command
        hw_addr = 3'b010;
        frame_start();
        send(8'h00);
        send(8'h04);
        chk("R6 load pulse", addr_load, 1);
        chk("R6 no reset", soft_rst_req, 0);
        frame_start();
        send(8'h24);
        chk("R6 field 0 now 0x24", ack, 1);
        frame_stop();

        // R7 alternate match and mismatch
        cfg_hwgc_en = 1;
        flag_clr = 1; @(negedge clk); flag_clr = 0;
        frame_start();
        send(8'h00);
        send(8'h35);
        chk("R7 hwgc set", hwgc_flag, 1);
        chk("R7 no command", addr_load, 0);
        flag_clr = 1; @(negedge clk); flag_clr = 0;
        frame_start();
        send(8'h00);
        send(8'h37);
        chk("R7 mismatch no hwgc", hwgc_flag, 0);
        frame_stop();

        // R5 set wins over clear
        frame_start();
        flag_clr = 1; byte_vld = 1; rx_byte = 8'h00;
        @(negedge clk);
        flag_clr = 0; byte_vld = 0;
        chk("R5 set beats clear", gc_status, 1);
        frame_stop();

        // R2 slave disabled
        cfg_slave_en = 0;
        frame_start();
        send(8'h42);
        chk("R2 disabled no ack", ack, 0);
        frame_start();
        send(8'h00);
        chk("R2 disabled no gc", ack, 0);
        frame_stop();

        repeat (3) @(negedge clk);
        report();
    end

endmodule